// File: doc/BRIEF.md
# Backlight PWM Generator with Pin Multiplexer

This block produces a pulse-width-modulated signal for dimming a display backlight. It is set up through a byte-wide synchronous register port. An 8-bit prescale value and a 16-bit period-scale value together set the length of each period in reference clock cycles. A 16-bit brightness level sets how many prescaled units of each period the output is active. A control register holds an enable bit and a polarity-invert bit.

The waveform leaves the block on one general-purpose pin, which is shared with ordinary GPIO output. A 2-bit selector field for that pin decides whether it carries the PWM signal or the GPIO value supplied from elsewhere. All other pins pass their GPIO values straight through.

Period settings are double-buffered. Firmware writes the two bytes of a 16-bit field in separate transactions. The running waveform does not pick up these writes until the current period ends, so a half-written field never produces a glitch.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset every register reads 0x00, the generator is disabled and every pin equals its `gpio_in` bit.
- R2: While enabled, one period lasts P*S+1 reference cycles. P is the effective prescale (R5) and S is the period-scale field.
- R3: Cycle k of a period (k = 0 .. P*S) is active when floor(k/P) < L, where L is the brightness level. The active time is therefore L*P cycles when L <= S.
- R4: A level of 0 keeps the output inactive for the whole period. A level of S+1 or more keeps it active for the whole period.
- R5: A prescale value of 0 behaves exactly like a value of 1.
- R6: Writes to prescale, period-scale or level reach the waveform only at the last cycle of the current period, or at any cycle while the generator is disabled.
- R7: Register map: prescale is at 0xA0. The period-scale field is at 0xA1 (low byte) and 0xA2 (high byte). The level field is at 0xA3 (low byte) and 0xA4 (high byte). Each address reads back the byte last written to it.
- R8: Control register 0xA5 holds bit 1 = enable and bit 0 = invert. Bits 7:2 read as zero. While disabled, the waveform is held at its inactive level. Invert flips the active and inactive levels, so a disabled, inverted output is high.
- R9: Register 0x16 holds 2-bit pin selectors. Bits 7:6 control pin 3. Selector code 2'b10 puts the PWM waveform on pin 3. Any other code, and every other pin, passes the matching `gpio_in` bit.
- R10: A write to an address outside 0x16 and 0xA0–0xA5 changes nothing, and reads of such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; counts PWM time |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 8 | Register address for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| gpio_in | input | 4 | Ordinary GPIO output values, one per pin |
| pin_out | output | 4 | Pin drive after the multiplexer |

## Verification
The in-RTL properties assume that the reference clock runs continuously and that `reg_we` is a clean, single-cycle-per-write strobe whose address and data are stable around the sampling edge. The bench drives every input half a cycle away from the active edge, issues one write per strobe, and changes `gpio_in` only between edges, so these assumptions always hold. Some scenarios reprogram fields while a period is in progress. Those writes also go through the same strobe, so the properties on the shadow registers see only legal update points.

// File: rtl/bl_pwm_pkg.sv
`timescale 1ns/1ps
package bl_pwm_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PRE_W   = 8;
  localparam int unsigned SCL_W   = 16;
  localparam int unsigned NPIN    = 4;
  localparam int unsigned PWM_PIN = 3;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned MUX_W   = SEL_W * NPIN;

  localparam logic [BYTE_W-1:0] ADR_PRE    = 8'hA0;
  localparam logic [BYTE_W-1:0] ADR_SCL_LO = 8'hA1;
  localparam logic [BYTE_W-1:0] ADR_SCL_HI = 8'hA2;
  localparam logic [BYTE_W-1:0] ADR_LVL_LO = 8'hA3;
  localparam logic [BYTE_W-1:0] ADR_LVL_HI = 8'hA4;
  localparam logic [BYTE_W-1:0] ADR_CTRL   = 8'hA5;
  localparam logic [BYTE_W-1:0] ADR_PINSEL = 8'h16;

  localparam int unsigned CTRL_INV_BIT = 0;
  localparam int unsigned CTRL_EN_BIT  = 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_GPIO0 = 2'b00,
    SEL_GPIO1 = 2'b01,
    SEL_PWM   = 2'b10,
    SEL_GPIO3 = 2'b11
  } pin_sel_e;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SCL_W-1:0] scl;
    logic [SCL_W-1:0] lvl;
  } pwm_cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
`timescale 1ns/1ps
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output pwm_cfg_t          cfg,
  output logic              en,
  output logic              inv,
  output logic [SEL_W-1:0]  pwm_pin_sel
);
  logic [PRE_W-1:0] pre_q;
  logic [SCL_W-1:0] scl_q, lvl_q;
  logic             en_q, inv_q;
  logic [MUX_W-1:0] sel_q;

  // write decode: one clock enable per byte register
  logic ld_pre, ld_scl_lo, ld_scl_hi, ld_lvl_lo, ld_lvl_hi, ld_ctrl, ld_sel;

  always_comb begin
    ld_pre    = we && (addr == ADR_PRE);
    ld_scl_lo = we && (addr == ADR_SCL_LO);
    ld_scl_hi = we && (addr == ADR_SCL_HI);
    ld_lvl_lo = we && (addr == ADR_LVL_LO);
    ld_lvl_hi = we && (addr == ADR_LVL_HI);
    ld_ctrl   = we && (addr == ADR_CTRL);
    ld_sel    = we && (addr == ADR_PINSEL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      scl_q <= '0;
      lvl_q <= '0;
      en_q  <= 1'b0;
      inv_q <= 1'b0;
      sel_q <= '0;
    end else begin
      if (ld_pre)    pre_q              <= wdata;
      if (ld_scl_lo) scl_q[7:0]         <= wdata;
      if (ld_scl_hi) scl_q[SCL_W-1:8]   <= wdata;
      if (ld_lvl_lo) lvl_q[7:0]         <= wdata;
      if (ld_lvl_hi) lvl_q[SCL_W-1:8]   <= wdata;
      if (ld_ctrl) begin
        en_q  <= wdata[CTRL_EN_BIT];
        inv_q <= wdata[CTRL_INV_BIT];
      end
      if (ld_sel)    sel_q              <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_PRE:    rdata = pre_q;
      ADR_SCL_LO: rdata = scl_q[7:0];
      ADR_SCL_HI: rdata = scl_q[SCL_W-1:8];
      ADR_LVL_LO: rdata = lvl_q[7:0];
      ADR_LVL_HI: rdata = lvl_q[SCL_W-1:8];
      ADR_CTRL: begin
        rdata[CTRL_EN_BIT]  = en_q;
        rdata[CTRL_INV_BIT] = inv_q;
      end
      ADR_PINSEL: rdata = sel_q;
      default:    rdata = '0;
    endcase
  end

  assign cfg         = '{pre: pre_q, scl: scl_q, lvl: lvl_q};
  assign en          = en_q;
  assign inv         = inv_q;
  assign pwm_pin_sel = sel_q[SEL_W*PWM_PIN +: SEL_W];

  // R8: reserved control bits never read back as one
  p_ctrl_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADR_CTRL) |-> (rdata[BYTE_W-1:2] == '0));

  // R10: a write to an unmapped address leaves the period settings unchanged
  p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr != ADR_PRE && addr != ADR_SCL_LO && addr != ADR_SCL_HI &&
     addr != ADR_LVL_LO && addr != ADR_LVL_HI && addr != ADR_CTRL &&
     addr != ADR_PINSEL) |=> ($stable(cfg) && $stable(en) && $stable(inv)));
endmodule

// File: rtl/bl_pwm_core.sv
`timescale 1ns/1ps
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pwm_cfg_t cfg,
  input  logic     en,
  output logic     pwm_raw
);
  pwm_cfg_t         act_q, act_d;
  logic [PRE_W-1:0] pre_cnt_q, pre_cnt_d;
  logic [SCL_W-1:0] unit_cnt_q, unit_cnt_d;
  logic [PRE_W-1:0] eff_pre;
  logic             pre_last, period_end, load_act;

  always_comb begin
    eff_pre    = (act_q.pre == '0) ? PRE_W'(1) : act_q.pre;
    pre_last   = (pre_cnt_q == eff_pre - PRE_W'(1));
    // the last unit of a period is a single extra reference cycle
    period_end = (unit_cnt_q == act_q.scl);
    load_act   = !en || period_end;
    act_d      = load_act ? cfg : act_q;
  end

  always_comb begin
    pre_cnt_d  = pre_cnt_q;
    unit_cnt_d = unit_cnt_q;
    if (!en || period_end) begin
      pre_cnt_d  = '0;
      unit_cnt_d = '0;
    end else if (pre_last) begin
      pre_cnt_d  = '0;
      unit_cnt_d = unit_cnt_q + SCL_W'(1);
    end else begin
      pre_cnt_d  = pre_cnt_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= '0;
      pre_cnt_q  <= '0;
      unit_cnt_q <= '0;
    end else begin
      if (load_act) act_q <= act_d;
      pre_cnt_q  <= pre_cnt_d;
      unit_cnt_q <= unit_cnt_d;
    end
  end

  assign pwm_raw = en && (unit_cnt_q < act_q.lvl);

  // R2: prescale counter stays within one effective prescale unit
  p_pre_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (pre_cnt_q < eff_pre));

  // R2: the unit counter never passes the active scale value
  p_unit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (unit_cnt_q <= act_q.scl));

  // R6: the active settings only move at a period end or while disabled
  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !period_end) |=> $stable(act_q));

  // R8: a disabled generator holds its counters at the start
  p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pre_cnt_q == '0 && unit_cnt_q == '0));

  // R4: level zero never produces an active cycle
  p_level_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.lvl == '0) |-> !pwm_raw);

  // R4: a level above the scale is active throughout an enabled period
  p_level_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_q.lvl > act_q.scl) |-> pwm_raw);
endmodule

// File: rtl/bl_pwm_pinmux.sv
`timescale 1ns/1ps
module bl_pwm_pinmux
  import bl_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  gpio_in,
  input  logic [SEL_W-1:0] pwm_pin_sel,
  input  logic             pwm_wave,
  output logic [NPIN-1:0]  pin_out
);
  logic use_pwm;
  assign use_pwm = (pin_sel_e'(pwm_pin_sel) == SEL_PWM);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    if (i == PWM_PIN) begin : g_shared
      assign pin_out[i] = use_pwm ? pwm_wave : gpio_in[i];
    end else begin : g_plain
      assign pin_out[i] = gpio_in[i];
    end
  end

  // R9: without the special selector the shared pin carries its GPIO value
  p_shared_pin_gpio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !use_pwm |-> (pin_out[PWM_PIN] == gpio_in[PWM_PIN]));
endmodule

// File: rtl/bl_pwm_top.sv
`timescale 1ns/1ps
module bl_pwm_top
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [BYTE_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [NPIN-1:0]   gpio_in,
  output logic [NPIN-1:0]   pin_out
);
  pwm_cfg_t         cfg;
  logic             en, inv, pwm_raw, pwm_wave;
  logic [SEL_W-1:0] pwm_pin_sel;

  bl_pwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg), .en(en),
    .inv(inv), .pwm_pin_sel(pwm_pin_sel)
  );

  bl_pwm_core u_core (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .en(en), .pwm_raw(pwm_raw)
  );

  assign pwm_wave = pwm_raw ^ inv;

  bl_pwm_pinmux u_pinmux (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .pwm_pin_sel(pwm_pin_sel),
    .pwm_wave(pwm_wave), .pin_out(pin_out)
  );

  // R8: a disabled generator drives the invert level onto the waveform
  p_disabled_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pwm_wave == inv));
endmodule

// File: tb/tb_bl_pwm_top.sv
`timescale 1ns/1ps
module tb_bl_pwm_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [3:0] gpio_in = 4'h0;
  logic [3:0] pin_out;

  int    total = 0;
  int    bad = 0;
  string tag = "R1";
  bit    finished = 0;

  // behavioural model state
  int m_pre, m_scl, m_lvl, m_en, m_inv, m_sel;
  int a_pre, a_scl, a_lvl, k;

  always #10 clk = ~clk;

  bl_pwm_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_in(gpio_in),
    .pin_out(pin_out)
  );

  function automatic int eff(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic logic [3:0] exp_pins();
    logic [3:0] v = gpio_in;
    logic raw = (m_en != 0) && ((k / eff(a_pre)) < a_lvl);
    if (((m_sel >> 6) & 3) == 2) v[3] = raw ^ (m_inv != 0);
    return v;
  endfunction

  function automatic int exp_read(input int a);
    case (a)
      8'hA0: return m_pre;
      8'hA1: return m_scl & 8'hFF;
      8'hA2: return (m_scl >> 8) & 8'hFF;
      8'hA3: return m_lvl & 8'hFF;
      8'hA4: return (m_lvl >> 8) & 8'hFF;
      8'hA5: return (m_en << 1) | m_inv;
      8'h16: return m_sel;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_scl = 0; m_lvl = 0; m_en = 0; m_inv = 0; m_sel = 0;
      a_pre = 0; a_scl = 0; a_lvl = 0; k = 0;
    end else begin
      if (m_en == 0 || k == eff(a_pre) * a_scl) begin
        k = 0; a_pre = m_pre; a_scl = m_scl; a_lvl = m_lvl;
      end else k = k + 1;
      if (reg_we) begin
        case (reg_addr)
          8'hA0: m_pre = reg_wdata;
          8'hA1: m_scl = (m_scl & 16'hFF00) | reg_wdata;
          8'hA2: m_scl = (m_scl & 16'h00FF) | (int'(reg_wdata) << 8);
          8'hA3: m_lvl = (m_lvl & 16'hFF00) | reg_wdata;
          8'hA4: m_lvl = (m_lvl & 16'h00FF) | (int'(reg_wdata) << 8);
          8'hA5: begin m_en = reg_wdata[1]; m_inv = reg_wdata[0]; end
          8'h16: m_sel = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(pin_out === exp_pins(), tag, "pins", pin_out, exp_pins());
      check(reg_rdata === 8'(exp_read(reg_addr)), tag, "rdata", reg_rdata, exp_read(reg_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] expv, input string req);
    @(negedge clk); #1;
    reg_addr = a;
    #2;
    check(reg_rdata === expv, req, "read", reg_rdata, expv);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // measure period and high time of pin 3 between two rising edges
  task automatic measure(input int exp_per, input int exp_hi, input string req);
    logic prev, cur;
    int per = 0, hi = 0, guard = 0;
    @(negedge clk); cur = pin_out[3];
    do begin
      prev = cur; @(negedge clk); cur = pin_out[3]; guard++;
    end while (!(!prev && cur) && guard < 3000);
    do begin
      if (cur) hi++;
      per++;
      prev = cur; @(negedge clk); cur = pin_out[3]; guard++;
    end while (!(!prev && cur) && guard < 6000);
    check(per == exp_per, req, "period", per, exp_per);
    check(hi == exp_hi, req, "high time", hi, exp_hi);
    #1;
  endtask

  task automatic count_high(input int n, input int expv, input string req);
    int hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin_out[3]) hi++;
    end
    check(hi == expv, req, "constant level count", hi, expv);
    #1;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    gpio_in = 4'b1010;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    tag = "R1";
    rd(8'hA0, 8'h00, "R1"); rd(8'hA2, 8'h00, "R1");
    rd(8'hA5, 8'h00, "R1"); rd(8'h16, 8'h00, "R1");
    check(pin_out === 4'b1010, "R1", "pins", pin_out, 4'b1010);

    // R7 byte layout
    tag = "R7";
    wr(8'hA1, 8'h34); wr(8'hA2, 8'h12);
    wr(8'hA3, 8'hCD); wr(8'hA4, 8'hAB);
    rd(8'hA1, 8'h34, "R7"); rd(8'hA2, 8'h12, "R7");
    rd(8'hA3, 8'hCD, "R7"); rd(8'hA4, 8'hAB, "R7");

    // R2 / R3 basic waveform on pin 3
    tag = "R2";
    wr(8'h16, 8'h80);
    wr(8'hA0, 8'd2); wr(8'hA1, 8'd3); wr(8'hA2, 8'd0);
    wr(8'hA3, 8'd2); wr(8'hA4, 8'd0);
    wr(8'hA5, 8'h02);
    rd(8'hA5, 8'h02, "R8");
    idle(20);
    measure(7, 4, "R2");
    tag = "R3";
    wr(8'hA0, 8'd3); wr(8'hA1, 8'd5); wr(8'hA3, 8'd4);
    idle(40);
    measure(16, 12, "R3");

    // R5 prescale zero
    tag = "R5";
    wr(8'hA0, 8'd0); wr(8'hA1, 8'd4); wr(8'hA3, 8'd1);
    idle(30);
    measure(5, 1, "R5");

    // R4 level extremes
    tag = "R4";
    wr(8'hA3, 8'd0);
    idle(10);
    count_high(30, 0, "R4");
    wr(8'hA1, 8'd3); wr(8'hA3, 8'hFF); wr(8'hA4, 8'hFF);
    idle(10);
    count_high(30, 30, "R4");
    wr(8'hA3, 8'd4); wr(8'hA4, 8'd0);
    idle(10);
    count_high(30, 30, "R4");

    // R6 mid-period update
    tag = "R6";
    wr(8'hA0, 8'd4); wr(8'hA1, 8'd10); wr(8'hA3, 8'd5);
    idle(100);
    measure(41, 20, "R6");
    idle(7);
    wr(8'hA3, 8'd2);
    wr(8'hA1, 8'd12);
    idle(100);
    measure(49, 8, "R6");

    // R8 invert and disable
    tag = "R8";
    wr(8'hA5, 8'h03);
    idle(60);
    measure(49, 41, "R8");
    wr(8'hA5, 8'hFD);
    rd(8'hA5, 8'h01, "R8");
    idle(5);
    count_high(20, 20, "R8");
    wr(8'hA5, 8'h00);
    idle(5);
    count_high(20, 0, "R8");
    wr(8'hA5, 8'h02);

    // R9 selector codes
    tag = "R9";
    wr(8'h16, 8'h40);
    gpio_in = 4'b1111; idle(3);
    check(pin_out === 4'b1111, "R9", "pins", pin_out, 4'b1111);
    wr(8'h16, 8'hC0);
    gpio_in = 4'b0101; idle(3);
    check(pin_out === 4'b0101, "R9", "pins", pin_out, 4'b0101);
    wr(8'h16, 8'h00);
    gpio_in = 4'b1000; idle(3);
    check(pin_out === 4'b1000, "R9", "pins", pin_out, 4'b1000);
    wr(8'h16, 8'h3F);
    gpio_in = 4'b0111; idle(3);
    check(pin_out[2:0] === 3'b111, "R9", "low pins", pin_out[2:0], 3'b111);

    // R10 unmapped addresses
    tag = "R10";
    wr(8'h30, 8'h55); wr(8'hA6, 8'hFF); wr(8'h9F, 8'hFF);
    rd(8'h30, 8'h00, "R10"); rd(8'hA6, 8'h00, "R10");
    rd(8'hA0, 8'd4, "R10"); rd(8'hA1, 8'd12, "R10");
    rd(8'hA5, 8'h02, "R10");
    idle(10);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule